// File: doc/BRIEF.md
# Idle-Cycle Sampling Monitor

This peripheral measures how busy a monitored processor or bus is. Software arms it through a control word. While it is armed, the block counts every clock cycle in which the monitored agent reports itself idle. A free-running millisecond tick from elsewhere in the chip sets the length of the window: a period field value of N gives N+1 milliseconds. When the last tick of the window arrives, the block does four things. It copies the idle count into a read-only status word, sets a sticky flag, drops its own arm bit and, if allowed, raises an interrupt line.

The block is one-shot. After a window it stays frozen, and the status word keeps its value until software reads it, clears the flag by writing 1 to it and arms the block again. The arm bit, the interrupt enable, the flag and the period all live in the same control word, so a single write can acknowledge the last sample and start the next. Any frequency policy built on the sample is left to software.

Top module: `idle_mon`

## Requirements
- R1: After reset the control word reads 0, the status word reads 0 and `irq_o` is low.
- R2: The control word is at offset 0x120. It holds the period in bits 27:20, the flag in bit 29, the interrupt enable in bit 30 and the arm bit in bit 31, and every other bit reads 0. The status word is at offset 0x124, and a read of any other offset returns 0.
- R3: With period value N, the window ends on the (N+1)-th millisecond tick that is sampled after the arming write.
- R4: At the end of the window, the status word holds the number of cycles with `idle_i` high between the cycle after the arming write and the closing cycle, both included.
- R5: At the end of the window the flag (bit 29) becomes 1 and the arm bit (bit 31) becomes 0.
- R6: Once a window has ended, further idle cycles and ticks have no effect. The status word stays the same until the next window ends.
- R7: Writing 1 to bit 29 clears the flag, and writing 0 to it leaves the flag unchanged.
- R8: `irq_o` is high exactly when both the flag and the interrupt enable (bit 30) are 1.
- R9: A control write with bit 31 set clears the idle count and the tick count and starts a fresh window, even in the middle of a window.
- R10: The idle counter saturates at its maximum value (2^CNT_W - 1) and does not wrap.
- R11: Writes to the status word are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the monitored domain |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register offset for reads and writes |
| we_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from `addr_i` |
| idle_i | input | 1 | High in each cycle the monitored agent is idle |
| ms_tick_i | input | 1 | One-cycle pulse each millisecond |
| irq_o | output | 1 | Sample-ready interrupt |

## Verification
On every cycle, the assertions check that the flag rises only at a window end, that a window end always drops the arm bit, that writing 0 to the flag keeps it, that the counter and status word stay frozen while the block is disarmed, and that a full counter stays full. Only the bench scenarios can show that the window length follows the period field and that the latched count equals the idle cycles the stimulus actually produced. They also show restarting mid-window, the interrupt gating and the status word ignoring writes. To cover these, the bench sweeps every small period against several idle patterns, and it uses a narrow-counter copy of the block to reach saturation.

// File: rtl/idle_mon_pkg.sv
package idle_mon_pkg;
  localparam int BIT_ARM   = 31;
  localparam int BIT_IE    = 30;
  localparam int BIT_FLAG  = 29;
  localparam int PER_LSB   = 20;
  localparam int PER_W     = 8;

  // saturating increment on a 32-bit carrier, limit supplied by caller
  function automatic logic [31:0] sat_inc(input logic [31:0] v, input logic [31:0] lim);
    return (v >= lim) ? lim : v + 32'd1;
  endfunction

  // last tick of a window: tick index equals the programmed period
  function automatic logic win_last(input logic [PER_W-1:0] ms, input logic [PER_W-1:0] per);
    return ms == per;
  endfunction
endpackage

// File: rtl/idle_mon_regs.sv
module idle_mon_regs
  import idle_mon_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctrl,
  input  logic [PER_W-1:0] w_per,
  input  logic             w_flag,
  input  logic             w_ie,
  input  logic             w_arm,
  input  logic             end_evt,
  output logic [PER_W-1:0] per_q,
  output logic             flag_q,
  output logic             ie_q,
  output logic             en_q,
  output logic             arm
);
  assign arm = wr_ctrl & w_arm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q  <= '0;
      flag_q <= 1'b0;
      ie_q   <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        per_q <= w_per;
        ie_q  <= w_ie;
        en_q  <= w_arm;
      end else if (end_evt) begin
        en_q <= 1'b0;
      end
      if (end_evt)                flag_q <= 1'b1;
      else if (wr_ctrl && w_flag) flag_q <= 1'b0;
    end
  end

  AST_FLAG_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(end_evt)); // R5
  AST_W1C_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !w_flag && flag_q) |=> flag_q); // R7
endmodule

// File: rtl/idle_mon_timer.sv
module idle_mon_timer
  import idle_mon_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             en,
  input  logic             tick,
  input  logic [PER_W-1:0] per,
  output logic             end_evt
);
  logic [PER_W-1:0] ms_q;

  assign end_evt = en & tick & ~arm & win_last(ms_q, per);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                ms_q <= '0;
    else if (arm)              ms_q <= '0;
    else if (en && tick && !end_evt) ms_q <= ms_q + 1'b1;
  end

  AST_TICKS_FROZEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !arm) |=> $stable(ms_q)); // R6
  AST_ARM_ZEROES_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (ms_q == '0)); // R9
endmodule

// File: rtl/idle_mon_count.sv
module idle_mon_count
  import idle_mon_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             en,
  input  logic             idle,
  input  logic             end_evt,
  output logic [CNT_W-1:0] stat_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nx;

  always_comb begin
    cnt_nx = cnt_q;
    if (en && idle) cnt_nx = CNT_W'(sat_inc(32'(cnt_q), 32'(CNT_MAX)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      stat_q <= '0;
    end else begin
      if (arm) cnt_q <= '0;
      else     cnt_q <= cnt_nx;
      if (end_evt) stat_q <= cnt_nx;
    end
  end

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !arm) |=> (cnt_q == CNT_MAX)); // R10
  AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !end_evt |=> $stable(stat_q)); // R6
  AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !arm) |=> $stable(cnt_q)); // R6
endmodule

// File: rtl/idle_mon.sv
module idle_mon
  import idle_mon_pkg::*;
#(
  parameter int              ADDR_W   = 12,
  parameter int              CNT_W    = 32,
  parameter logic [ADDR_W-1:0] CTRL_OFS = ADDR_W'(12'h120),
  parameter logic [ADDR_W-1:0] STAT_OFS = ADDR_W'(12'h124)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              idle_i,
  input  logic              ms_tick_i,
  output logic              irq_o
);
  logic             wr_ctrl;
  logic             arm;
  logic             end_evt;
  logic [PER_W-1:0] per_q;
  logic             flag_q, ie_q, en_q;
  logic [CNT_W-1:0] stat_q;
  logic [31:0]      stat_word;
  logic [31:0]      ctrl_word;

  assign wr_ctrl = we_i && (addr_i == CTRL_OFS);

  idle_mon_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl),
    .w_per(wdata_i[PER_LSB +: PER_W]), .w_flag(wdata_i[BIT_FLAG]),
    .w_ie(wdata_i[BIT_IE]), .w_arm(wdata_i[BIT_ARM]),
    .end_evt(end_evt), .per_q(per_q), .flag_q(flag_q), .ie_q(ie_q),
    .en_q(en_q), .arm(arm)
  );

  idle_mon_timer u_timer (
    .clk(clk), .rst_n(rst_n), .arm(arm), .en(en_q), .tick(ms_tick_i),
    .per(per_q), .end_evt(end_evt)
  );

  idle_mon_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .arm(arm), .en(en_q), .idle(idle_i),
    .end_evt(end_evt), .stat_q(stat_q)
  );

  generate
    if (CNT_W < 32) begin : g_pad
      assign stat_word = {{(32-CNT_W){1'b0}}, stat_q};
    end else begin : g_full
      assign stat_word = stat_q[31:0];
    end
  endgenerate

  always_comb begin
    ctrl_word = '0;
    ctrl_word[PER_LSB +: PER_W] = per_q;
    ctrl_word[BIT_FLAG] = flag_q;
    ctrl_word[BIT_IE]   = ie_q;
    ctrl_word[BIT_ARM]  = en_q;
  end

  always_comb begin
    if (addr_i == CTRL_OFS)      rdata_o = ctrl_word;
    else if (addr_i == STAT_OFS) rdata_o = stat_word;
    else                         rdata_o = '0;
  end

  assign irq_o = flag_q & ie_q;

  AST_END_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt |=> (!en_q && flag_q)); // R5
  AST_NO_END_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !end_evt); // R6
endmodule

// File: tb/test_idle_mon.sv
module test_idle_mon;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic        idle = 1'b0;
  logic        tick = 1'b0;
  logic [31:0] rdata, rdata_s;
  logic        irq, irq_s;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // model state
  bit        m_en, m_ie, m_flag;
  int        m_per, m_ms, m_cnt, m_stat;

  always #10 clk = ~clk;

  idle_mon i_idle_mon (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .idle_i(idle), .ms_tick_i(tick), .irq_o(irq)
  );

  idle_mon #(.CNT_W(4)) i_idle_mon_small (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata_s), .idle_i(idle), .ms_tick_i(tick), .irq_o(irq_s)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  function automatic logic [31:0] ctrl_exp();
    return {m_en, m_ie, m_flag, 1'b0, 8'(m_per), 20'h0};
  endfunction

  // one clock with given idle/tick, model advanced per R3/R4/R5
  task automatic step(input bit id, input bit tk);
    idle = id; tick = tk;
    @(posedge clk);
    if (m_en) begin
      if (id) m_cnt++;
      if (tk) begin
        if (m_ms == m_per) begin
          m_stat = m_cnt; m_flag = 1; m_en = 0;
        end else m_ms++;
      end
    end
    @(negedge clk);
    idle = 0; tick = 0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1;
    @(posedge clk);
    if (a == 12'h120) begin
      m_per = int'(d[27:20]); m_ie = d[30]; m_en = d[31];
      if (d[29]) m_flag = 0;
      if (d[31]) begin m_cnt = 0; m_ms = 0; end
    end
    @(negedge clk);
    we = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic [31:0] ds);
    addr = a; #1; d = rdata; ds = rdata_s;
  endtask

  function automatic bit pat_idle(input int p, input int i);
    case (p)
      0: return 0;
      1: return 1;
      2: return (i % 2) == 0;
      default: return (i % 3) != 0;
    endcase
  endfunction

  task automatic run_to_end(input int p);
    int i = 0;
    while (m_en && i < 4000) begin
      step(pat_idle(p, i), (i % 4) == 3);
      i++;
    end
  endtask

  task automatic check_window(input string tag);
    logic [31:0] d, ds;
    int sat;
    rd(12'h124, d, ds);
    check({tag, " R4 status"}, d, 32'(m_stat));
    sat = (m_stat > 15) ? 15 : m_stat;
    check({tag, " R10 small status"}, ds, 32'(sat));
    rd(12'h120, d, ds);
    check({tag, " R5 ctrl after end"}, d, ctrl_exp());
    check({tag, " R8 irq"}, {31'h0, irq}, {31'h0, m_flag & m_ie});
  endtask

  initial begin
    logic [31:0] d, ds;
    m_en = 0; m_ie = 0; m_flag = 0; m_per = 0; m_ms = 0; m_cnt = 0; m_stat = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd(12'h120, d, ds); check("R1 ctrl reset", d, 32'h0);
    rd(12'h124, d, ds); check("R1 status reset", d, 32'h0);
    check("R1 irq reset", {31'h0, irq}, 32'h0);
    rd(12'h200, d, ds); check("R2 unmapped read", d, 32'h0);

    // R2 readback of period and enable, reserved bits drop
    wr(12'h120, 32'h5AB0_0000 | 32'h1000_FFFF);
    rd(12'h120, d, ds); check("R2 ctrl readback", d, ctrl_exp());
    wr(12'h120, 32'h0);

    // R3 R4 R5 R8 sweep over periods and idle patterns
    for (int per = 0; per < 4; per++) begin
      for (int p = 0; p < 4; p++) begin
        wr(12'h120, 32'hC000_0000 | (32'(per) << 20));
        run_to_end(p);
        check("R3 window closed", {31'h0, m_en}, 32'h0);
        // R6 no counting or restart after end
        repeat (6) step(1, 1);
        check_window("sweep");
        // R7 write 0 to flag keeps it
        wr(12'h120, 32'h4000_0000 | (32'(per) << 20));
        rd(12'h120, d, ds); check("R7 flag kept on 0", d, ctrl_exp());
        check("R8 irq still high", {31'h0, irq}, 32'h1);
        // R7 write 1 clears
        wr(12'h120, 32'h6000_0000 | (32'(per) << 20));
        rd(12'h120, d, ds); check("R7 flag cleared", d, ctrl_exp());
        check("R8 irq low after clear", {31'h0, irq}, 32'h0);
      end
    end

    // R3 exact tick count: period 2 ends on third tick only
    wr(12'h120, 32'h8020_0000);
    step(1, 1); step(1, 1);
    rd(12'h120, d, ds); check("R3 still armed after two ticks", d[31:0], ctrl_exp());
    step(1, 1);
    rd(12'h124, d, ds); check("R3 R4 ends on third tick", d, 32'd3);

    // R8 interrupt gated by enable
    rd(12'h120, d, ds); check("R8 flag without ie", d, ctrl_exp());
    check("R8 irq gated", {31'h0, irq}, 32'h0);
    wr(12'h120, 32'h4000_0000);
    check("R8 irq after enable", {31'h0, irq}, 32'h1);

    // R11 status writes ignored
    wr(12'h124, 32'hFFFF_FFFF);
    rd(12'h124, d, ds); check("R11 status unchanged", d, 32'd3);
    rd(12'h120, d, ds); check("R11 ctrl unchanged", d, ctrl_exp());

    // R9 re-arm mid-window clears counts
    wr(12'h120, 32'hE010_0000);
    for (int i = 0; i < 6; i++) step(1, i == 2);
    wr(12'h120, 32'hC010_0000);
    for (int i = 0; i < 12 && m_en; i++) step(i < 5, i % 4 == 3);
    check_window("R9 rearm");
    check("R9 expected count", 32'(m_stat), 32'd5);

    // R10 long all-idle window saturates the narrow copy
    wr(12'h120, 32'hE030_0000);
    run_to_end(1);
    check_window("R10 long");

    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule